// File: doc/BRIEF.md
# Decode-Stage Hazard Interlock

This block sits in the decode stage of a five-stage in-order pipeline and decides, within the current cycle, whether the instruction being decoded must wait. It compares the two source register indices of the decode instruction, each qualified by its own read flag, against the destination indices of the instructions now in execute, memory and writeback. Each of those is qualified by its own write flag. When a real dependence exists, it raises a stall that keeps the program counter and the decode instruction register where they are and sends an empty slot into execute.

A parameter fixes the operating variant at elaboration. With `BYPASS_EN = 0` no forwarding paths exist, so any pending write from the three older stages forces a wait. With `BYPASS_EN = 1` every result is assumed to be forwarded, and the only wait left is for a load in execute whose result the next instruction needs. In both variants a branch resolved as taken in execute makes the decode instruction dead, so the stall is dropped. The execute slot is still emptied.

All inputs are expected to come from pipeline-stage registers. Both outputs are pure combinational functions of those inputs.

Top module: `hazard_stall_unit`

## Requirements
- R1: With `BYPASS_EN = 0`, `stall` is 1 when a decode source with its read flag set equals the destination of the execute, memory or writeback instruction, that instruction has its write flag set, the destination is non-zero, and no taken branch is present. This holds for source 1 and source 2 alike.
- R2: An older instruction whose write flag is 0 never causes `stall`, whatever its destination.
- R3: A decode source whose read flag is 0 never causes `stall`, even when its index matches a pending destination.
- R4: A destination index of 0 never causes `stall`, even with the write flag set.
- R5: With `BYPASS_EN = 1`, `stall` is 1 only when a read-enabled source matches the non-zero, write-enabled destination of the execute instruction, `ex_load` is 1, and no taken branch is present. Matches in memory or writeback, and matches on a non-load in execute, give 0.
- R6: A branch is taken when `ex_br_kind` is 2'b01 (branch if zero) and `ex_zero` is 1, or when `ex_br_kind` is 2'b10 (branch if non-zero) and `ex_zero` is 0. A taken branch forces `stall` to 0.
- R7: `ex_nop` is 1 exactly when `stall` is 1 or a taken branch is present; otherwise it is 0.
- R8: `ex_br_kind` of 2'b00 or 2'b11, and a branch whose condition fails, do not suppress `stall`.
- R9: With all flags 0 and all indices 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| de_src1 | input | REG_AW | First source register index of the decode instruction |
| de_src1_rd | input | 1 | Decode instruction reads its first source |
| de_src2 | input | REG_AW | Second source register index of the decode instruction |
| de_src2_rd | input | 1 | Decode instruction reads its second source |
| ex_dst | input | REG_AW | Destination index of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_br_kind | input | 2 | Execute branch type: 00 none, 01 if zero, 10 if non-zero, 11 none |
| ex_zero | input | 1 | Zero test result of the execute branch operand |
| mem_dst | input | REG_AW | Destination index of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_AW | Destination index of the writeback instruction |
| wb_wr | input | 1 | Writeback instruction writes a register |
| stall | output | 1 | Hold PC and decode register this cycle |
| ex_nop | output | 1 | Load an empty slot into execute at the next edge |

## Verification
No register lies between any input and `stall` or `ex_nop`, so both results are due in the same cycle as the stimulus that causes them. The bench changes inputs one time step after a rising clock edge. It reads the outputs at the following falling edge, half a period later, when every input for that cycle is stable. Two instances share the stimulus, one per value of `BYPASS_EN`, so every pattern is checked against both variants in the same cycle.

// File: rtl/hsu_pkg.sv
package hsu_pkg;
   localparam int unsigned NUM_SRC = 2;
   localparam int unsigned NUM_STG = 3;   // 0: execute, 1: memory, 2: writeback
   localparam int unsigned STG_EX  = 0;

   typedef enum logic [1:0] {
      BRK_NONE = 2'b00,
      BRK_IFZ  = 2'b01,
      BRK_IFNZ = 2'b10,
      BRK_RSVD = 2'b11
   } br_kind_e;
endpackage

// File: rtl/hsu_stage_cmp.sv
module hsu_stage_cmp #(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic              src_rd,
   input  logic [REG_AW-1:0] dst,
   input  logic              dst_wr,
   output logic              hit
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic dst_live;
   assign dst_live = dst_wr && (dst != ZERO_REG);
   assign hit      = src_rd && dst_live && (src == dst);
endmodule

// File: rtl/hsu_branch_eval.sv
module hsu_branch_eval
   import hsu_pkg::*;
(
   input  logic [1:0] kind,
   input  logic       zero,
   output logic       taken
);
   br_kind_e k;
   assign k = br_kind_e'(kind);

   always_comb begin
      unique case (k)
         BRK_IFZ:  taken = zero;
         BRK_IFNZ: taken = !zero;
         default:  taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/hsu_policy.sv
module hsu_policy #(
   parameter int unsigned BYPASS_EN = 0,
   parameter int unsigned NUM_SRC   = 2,
   parameter int unsigned NUM_STG   = 3,
   parameter int unsigned STG_EX    = 0
) (
   input  logic [NUM_SRC*NUM_STG-1:0] hit,
   input  logic                       ex_load,
   input  logic                       kill,
   output logic                       stall
);
   logic need;

   generate
      if (BYPASS_EN != 0) begin : g_bypassed
         logic [NUM_SRC-1:0] ex_hit;
         for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign ex_hit[s] = hit[s*NUM_STG + STG_EX];
         end
         assign need = ex_load && (|ex_hit);
      end else begin : g_interlocked
         assign need = |hit;
      end
   endgenerate

   assign stall = need && !kill;
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
   import hsu_pkg::*;
#(
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned BYPASS_EN = 0
) (
   input  logic [REG_AW-1:0] de_src1,
   input  logic              de_src1_rd,
   input  logic [REG_AW-1:0] de_src2,
   input  logic              de_src2_rd,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_wr,
   input  logic              ex_load,
   input  logic [1:0]        ex_br_kind,
   input  logic              ex_zero,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wr,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic              wb_wr,
   output logic              stall,
   output logic              ex_nop
);
   localparam int unsigned NHIT = NUM_SRC * NUM_STG;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("hazard_stall_unit: REG_AW must lie in 1..8");
   end
   if (BYPASS_EN > 1) begin : g_bad_mode
      $error("hazard_stall_unit: BYPASS_EN must be 0 or 1");
   end

   logic [REG_AW-1:0] src_idx [NUM_SRC];
   logic              src_rd  [NUM_SRC];
   logic [REG_AW-1:0] stg_dst [NUM_STG];
   logic              stg_wr  [NUM_STG];

   assign src_idx[0] = de_src1;
   assign src_rd[0]  = de_src1_rd;
   assign src_idx[1] = de_src2;
   assign src_rd[1]  = de_src2_rd;

   assign stg_dst[0] = ex_dst;
   assign stg_wr[0]  = ex_wr;
   assign stg_dst[1] = mem_dst;
   assign stg_wr[1]  = mem_wr;
   assign stg_dst[2] = wb_dst;
   assign stg_wr[2]  = wb_wr;

   logic [NHIT-1:0] raw_hit;
   logic            br_taken;
   logic            stall_int;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      for (genvar g = 0; g < NUM_STG; g++) begin : g_stg
         hsu_stage_cmp #(.REG_AW(REG_AW)) u_cmp (
            .src    (src_idx[s]),
            .src_rd (src_rd[s]),
            .dst    (stg_dst[g]),
            .dst_wr (stg_wr[g]),
            .hit    (raw_hit[s*NUM_STG + g])
         );
      end
   end

   hsu_branch_eval u_br (
      .kind  (ex_br_kind),
      .zero  (ex_zero),
      .taken (br_taken)
   );

   hsu_policy #(
      .BYPASS_EN (BYPASS_EN),
      .NUM_SRC   (NUM_SRC),
      .NUM_STG   (NUM_STG),
      .STG_EX    (STG_EX)
   ) u_pol (
      .hit     (raw_hit),
      .ex_load (ex_load),
      .kill    (br_taken),
      .stall   (stall_int)
   );

   assign stall  = stall_int;
   assign ex_nop = stall_int || br_taken;
endmodule

// File: rtl/hazard_stall_unit_chk.sv
module hazard_stall_unit_chk #(
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned BYPASS_EN = 0
) (
   input logic [REG_AW-1:0] de_src1,
   input logic              de_src1_rd,
   input logic [REG_AW-1:0] de_src2,
   input logic              de_src2_rd,
   input logic [REG_AW-1:0] ex_dst,
   input logic              ex_wr,
   input logic              ex_load,
   input logic [REG_AW-1:0] mem_dst,
   input logic              mem_wr,
   input logic [REG_AW-1:0] wb_dst,
   input logic              wb_wr,
   input logic              br_taken,
   input logic              stall,
   input logic              ex_nop
);
   logic known;
   assign known = !$isunknown({de_src1, de_src1_rd, de_src2, de_src2_rd,
                               ex_dst, ex_wr, ex_load, mem_dst, mem_wr,
                               wb_dst, wb_wr, br_taken, stall, ex_nop});

   always_comb begin
      if (known) begin
         if (!ex_wr && !mem_wr && !wb_wr)
            a_r2_idle_writers: assert (!stall);
         if (!de_src1_rd && !de_src2_rd)
            a_r3_no_readers: assert (!stall);
         if (ex_dst == '0 && mem_dst == '0 && wb_dst == '0)
            a_r4_zero_dest: assert (!stall);
         if (BYPASS_EN != 0 && stall)
            a_r5_load_only: assert (ex_load && ex_wr);
         if (br_taken)
            a_r6_branch_kill: assert (!stall);
         if (stall)
            a_r7_stall_bubbles: assert (ex_nop);
         if (ex_nop && !stall)
            a_r7_nop_cause: assert (br_taken);
         if (stall)
            a_r1_needs_reader: assert (de_src1_rd || de_src2_rd);
      end
   end
endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(
   .REG_AW    (REG_AW),
   .BYPASS_EN (BYPASS_EN)
) u_chk (
   .de_src1    (de_src1),
   .de_src1_rd (de_src1_rd),
   .de_src2    (de_src2),
   .de_src2_rd (de_src2_rd),
   .ex_dst     (ex_dst),
   .ex_wr      (ex_wr),
   .ex_load    (ex_load),
   .mem_dst    (mem_dst),
   .mem_wr     (mem_wr),
   .wb_dst     (wb_dst),
   .wb_wr      (wb_wr),
   .br_taken   (br_taken),
   .stall      (stall),
   .ex_nop     (ex_nop)
);

// File: tb/hazard_stall_unit_tb.sv
module hazard_stall_unit_tb;
   localparam int AW = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [AW-1:0] s1, s2, exd, memd, wbd;
   logic          s1r, s2r, exw, exl, ez, memw, wbw;
   logic [1:0]    bk;
   logic          st_i, nop_i, st_b, nop_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   hazard_stall_unit #(.REG_AW(AW), .BYPASS_EN(0)) u_dut (
      .de_src1(s1), .de_src1_rd(s1r), .de_src2(s2), .de_src2_rd(s2r),
      .ex_dst(exd), .ex_wr(exw), .ex_load(exl), .ex_br_kind(bk), .ex_zero(ez),
      .mem_dst(memd), .mem_wr(memw), .wb_dst(wbd), .wb_wr(wbw),
      .stall(st_i), .ex_nop(nop_i));

   hazard_stall_unit #(.REG_AW(AW), .BYPASS_EN(1)) u_dut_byp (
      .de_src1(s1), .de_src1_rd(s1r), .de_src2(s2), .de_src2_rd(s2r),
      .ex_dst(exd), .ex_wr(exw), .ex_load(exl), .ex_br_kind(bk), .ex_zero(ez),
      .mem_dst(memd), .mem_wr(memw), .wb_dst(wbd), .wb_wr(wbw),
      .stall(st_b), .ex_nop(nop_b));

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic idle();
      s1 = '0; s2 = '0; exd = '0; memd = '0; wbd = '0;
      s1r = 0; s2r = 0; exw = 0; exl = 0; ez = 0; memw = 0; wbw = 0; bk = 2'b00;
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   // Reference built from the requirement text.
   function automatic logic hit(logic [AW-1:0] src, logic rd, logic [AW-1:0] dst, logic wr);
      return rd && wr && (dst != '0) && (src == dst);
   endfunction

   function automatic logic taken();
      return (bk == 2'b01 && ez) || (bk == 2'b10 && !ez);
   endfunction

   function automatic logic ref_stall(bit byp);
      logic e, o;
      e = hit(s1, s1r, exd, exw) || hit(s2, s2r, exd, exw);
      o = hit(s1, s1r, memd, memw) || hit(s2, s2r, memd, memw) ||
          hit(s1, s1r, wbd, wbw) || hit(s2, s2r, wbd, wbw);
      if (byp) return e && exl && !taken();
      return (e || o) && !taken();
   endfunction

   // Drive a pattern one step after the edge, check at the falling edge.
   task automatic expect_both(input string req, input logic ei, input logic eb,
                              input logic ni, input logic nb);
      @(negedge clk);
      chk(req, "interlock stall", st_i, ei);
      chk(req, "bypass stall",    st_b, eb);
      chk(req, "interlock ex_nop", nop_i, ni);
      chk(req, "bypass ex_nop",    nop_b, nb);
   endtask

   task automatic t_reset_idle();
      step(); idle();
      expect_both("R9", 0, 0, 0, 0);
   endtask

   // Producer at distance d (1 execute, 2 memory, 3 writeback), consumer on source 1 or 2.
   task automatic t_distance(input int d, input bit use_src2, input bit is_load);
      step(); idle();
      if (use_src2) begin s2 = 5'd7; s2r = 1; s1 = 5'd3; s1r = 1; end
      else          begin s1 = 5'd7; s1r = 1; end
      case (d)
         1: begin exd = 5'd7; exw = 1; exl = is_load; end
         2: begin memd = 5'd7; memw = 1; end
         default: begin wbd = 5'd7; wbw = 1; end
      endcase
      expect_both(d == 1 && is_load ? "R5" : "R1", 1, (d == 1 && is_load), 1, (d == 1 && is_load));
   endtask

   task automatic t_load_use();
      step(); idle();
      s1 = 5'd12; s1r = 1; s2 = 5'd9; s2r = 1;
      exd = 5'd9; exw = 1; exl = 1;
      expect_both("R5", 1, 1, 1, 1);
      step(); exl = 0;   // same dependence on an arithmetic producer
      expect_both("R5", 1, 0, 1, 0);
   endtask

   task automatic t_no_write();
      step(); idle();
      s1 = 5'd4; s1r = 1; s2 = 5'd5; s2r = 1;
      exd = 5'd4; exl = 1; memd = 5'd5; wbd = 5'd4;
      expect_both("R2", 0, 0, 0, 0);
   endtask

   task automatic t_no_read();
      step(); idle();
      s1 = 5'd6; s2 = 5'd6;
      exd = 5'd6; exw = 1; exl = 1; memd = 5'd6; memw = 1;
      expect_both("R3", 0, 0, 0, 0);
      step(); s2r = 1;   // only source 2 read
      expect_both("R3", 1, 1, 1, 1);
   endtask

   task automatic t_zero_reg();
      step(); idle();
      s1r = 1; s2r = 1;
      exw = 1; exl = 1; memw = 1; wbw = 1;
      expect_both("R4", 0, 0, 0, 0);
   endtask

   task automatic t_branch();
      step(); idle();
      s1 = 5'd8; s1r = 1; exd = 5'd8; exw = 1; exl = 1;
      bk = 2'b01; ez = 1;
      expect_both("R6", 0, 0, 1, 1);
      step(); bk = 2'b10; ez = 0;
      expect_both("R6", 0, 0, 1, 1);
      step(); bk = 2'b01; ez = 0;
      expect_both("R8", 1, 1, 1, 1);
      step(); bk = 2'b10; ez = 1;
      expect_both("R8", 1, 1, 1, 1);
      step(); bk = 2'b11; ez = 1;
      expect_both("R8", 1, 1, 1, 1);
      step(); exw = 0; bk = 2'b01; ez = 1;   // taken branch, no hazard
      expect_both("R7", 0, 0, 1, 1);
   endtask

   task automatic t_sweep();
      logic [31:0] lfsr = 32'h1ace_b00c;
      for (int i = 0; i < 400; i++) begin
         step();
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         s1 = {3'b0, lfsr[1:0]};  s2 = {3'b0, lfsr[3:2]};
         exd = {3'b0, lfsr[5:4]}; memd = {3'b0, lfsr[7:6]}; wbd = {3'b0, lfsr[9:8]};
         s1r = lfsr[10]; s2r = lfsr[11]; exw = lfsr[12]; exl = lfsr[13];
         memw = lfsr[14]; wbw = lfsr[15]; ez = lfsr[16]; bk = lfsr[18:17];
         expect_both("R1", ref_stall(0), ref_stall(1),
                     ref_stall(0) || taken(), ref_stall(1) || taken());
      end
   endtask

   initial begin
      idle();
      t_reset_idle();
      for (int d = 1; d <= 3; d++) begin
         t_distance(d, 0, 0);
         t_distance(d, 1, 0);
         t_distance(d, 0, 1);
      end
      t_load_use();
      t_no_write();
      t_no_read();
      t_zero_reg();
      t_branch();
      t_sweep();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 50000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule